// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block sits between a host and a 14-bit serial analog-to-digital converter. The host sends a start request. The block then runs one capture frame. It pulls chip select low and toggles a divided serial clock. It shifts in one result bit per serial clock, MSB first. After the data bits it runs one or two extra guard clocks, then raises chip select again. The finished word is presented on a parallel bus together with a single-cycle strobe. The block also holds the converter's framing-select pin fixed at the serial-peripheral setting. It pulses the converter's reset line after its own reset.

A busy flag covers the whole frame plus a short gap in which chip select stays high. Start requests that arrive while busy is high are dropped. In free-running mode an internal timer makes the requests at a programmable period. Timer requests that land while the block is busy are counted in a saturating overrun counter. The serial clock divide ratio is a build parameter with a minimum of 2. Every output is a register or a decode of registered state, so all outputs move only on system clock edges.

Top module: `adc_frame_ctrl`

## Requirements
- R1: The framing-select output `adc_fs` is 1 at all times, including during reset.
- R2: While `rst_n` is low, and for `RST_CYC` system clocks after it is released, `adc_rst` is 1. During that time `adc_cs_n` is 1, `busy_o` is 1 and start requests are ignored. A request held high is accepted two cycles after `adc_rst` falls.
- R3: A request seen while idle pulls `adc_cs_n` low on the next clock. The frame contains 14+g serial clock rising edges and keeps `adc_cs_n` low for `CLK_DIV`*(14+g) system clocks. g is 1 when `guard2_i` is 0 and 2 when it is 1. `guard2_i` is sampled when the request is accepted.
- R4: `adc_sclk` is 0 whenever `adc_cs_n` is 1. Within a frame, each serial period is `CLK_DIV`-`CLK_DIV`/2 clocks low followed by `CLK_DIV`/2 clocks high.
- R5: After `adc_cs_n` rises it stays high for at least `CLK_DIV` clocks. `busy_o` stays 1 for exactly `CLK_DIV` clocks after the rise and then drops to 0.
- R6: `busy_o` is 1 from the accepting edge until the end of the gap. A start request made while `busy_o` is 1 starts no frame, either then or later.
- R7: `adc_sdo` is captured on the system clock edge where `adc_sclk` goes from 1 to 0, during the first 14 serial periods only. The first captured bit is result bit 13 (MSB). `data_o` holds the captured bits in arrival order, MSB first.
- R8: `valid_o` is 1 for exactly one cycle, in the same cycle `adc_cs_n` rises. `data_o` keeps that word until the next strobe.
- R9: With `free_run_i` at 1 and a period P in `period_i`, an internal request is made at the P-th, 2P-th, ... clock edge after the edge where `free_run_i` is first seen as 1. The timer restarts whenever `free_run_i` is 0.
- R10: Each internal request made while `busy_o` is 1 adds one to `overrun_o`, which saturates at its maximum and never decreases. Accepted and dropped internal requests together equal the number made.
- R11: With a start request held high, `adc_cs_n` stays high for exactly `CLK_DIV`+1 clocks between frames. The frame period is therefore `CLK_DIV`*(15+g)+1 clocks, which is 33 clocks at divide 2 with one guard clock, so a 41.25 MHz system clock reaches 1.25 M conversions per second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| start_i | input | 1 | Host start request, level or pulse |
| guard2_i | input | 1 | 0: one guard clock, 1: two guard clocks |
| free_run_i | input | 1 | Enables the internal request timer |
| period_i | input | PER_W | Free-running request period in system clocks (at least 1) |
| busy_o | output | 1 | Frame or gap or converter reset in progress |
| data_o | output | DATA_W | Last captured conversion result |
| valid_o | output | 1 | One-cycle strobe when a new result is presented |
| overrun_o | output | OVR_W | Saturating count of dropped internal requests |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_fs | output | 1 | Converter framing select, fixed high |
| adc_rst | output | 1 | Converter reset, active high |
| adc_sdo | input | 1 | Converter serial data |

## Verification
The bench builds the block with `CLK_DIV` = 3 and `RST_CYC` = 5. The odd divide gives unequal low and high halves of the serial clock, so it exposes off-by-one errors in the phase decode and in the capture point. The short reset makes the reset release and the first accepted request cheap to step through. Small free-running periods of 60 and 20 clocks fall on either side of the 48-clock busy span, so both a clean run and a regular drop pattern of the overrun counter are reached. Each result pattern is run with both guard settings.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
    typedef enum logic [1:0] {
        ST_CONV_RST,
        ST_IDLE,
        ST_SHIFT,
        ST_GAP
    } frame_st_e;
endpackage

// File: rtl/adc_rst_seq.sv
// Holds the converter reset line high for a fixed number of clocks after the
// controller leaves reset.
module adc_rst_seq #(
    parameter int RST_CYC = 16,
    localparam int CW = $clog2(RST_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic conv_rst_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.cnt < CW'(RST_CYC))
            seq_d.cnt = seq_q.cnt + 1'b1;
        seq_d.hold = (seq_d.cnt < CW'(RST_CYC));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.cnt  <= '0;
            seq_q.hold <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign conv_rst_o = seq_q.hold;
endmodule

// File: rtl/adc_rate_gen.sv
// Free-running request timer and saturating overrun counter.
module adc_rate_gen #(
    parameter int PER_W = 16,
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             busy_i,
    output logic             tick_o,
    output logic [OVR_W-1:0] ovr_o
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [OVR_W-1:0] ovr;
    } rate_t;

    rate_t rate_d, rate_q;
    logic  tick;

    assign tick = en_i && (rate_q.cnt == period_i - 1'b1);

    always_comb begin
        rate_d = rate_q;
        if (!en_i || tick)
            rate_d.cnt = '0;
        else
            rate_d.cnt = rate_q.cnt + 1'b1;
        if (tick && busy_i && (rate_q.ovr != {OVR_W{1'b1}}))
            rate_d.ovr = rate_q.ovr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
        end else begin
            rate_q <= rate_d;
        end
    end

    assign tick_o = tick;
    assign ovr_o  = rate_q.ovr;
endmodule

// File: rtl/adc_frame_fsm.sv
// Frame sequencer: chip select, divided serial clock, MSB-first capture.
module adc_frame_fsm
    import adc_frame_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int CLK_DIV = 2,
    localparam int PH_W   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1,
    localparam int LO_CYC = CLK_DIV - CLK_DIV / 2,
    localparam int CNT_W  = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_ready_i,
    input  logic              req_i,
    input  logic              guard2_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    typedef struct packed {
        frame_st_e         st;
        logic [PH_W-1:0]   phase;
        logic [CNT_W-1:0]  pcnt;
        logic              guard2;
        logic              cs_n;
        logic              sclk;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] data;
        logic              valid;
    } fsm_t;

    fsm_t             fsm_d, fsm_q;
    logic             wrap;
    logic [CNT_W-1:0] last;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.valid = 1'b0;
        wrap        = (fsm_q.phase == PH_W'(CLK_DIV - 1));
        last        = fsm_q.guard2 ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
        case (fsm_q.st)
            ST_CONV_RST: begin
                if (conv_ready_i)
                    fsm_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_i) begin
                    fsm_d.st     = ST_SHIFT;
                    fsm_d.cs_n   = 1'b0;
                    fsm_d.sclk   = 1'b0;
                    fsm_d.phase  = '0;
                    fsm_d.pcnt   = '0;
                    fsm_d.guard2 = guard2_i;
                end
            end
            ST_SHIFT: begin
                fsm_d.phase = wrap ? '0 : fsm_q.phase + 1'b1;
                fsm_d.sclk  = (fsm_d.phase >= PH_W'(LO_CYC));
                if (wrap) begin
                    if (fsm_q.pcnt < CNT_W'(DATA_W))
                        fsm_d.shreg = {fsm_q.shreg[DATA_W-2:0], sdo_i};
                    if (fsm_q.pcnt == last) begin
                        fsm_d.st    = ST_GAP;
                        fsm_d.cs_n  = 1'b1;
                        fsm_d.sclk  = 1'b0;
                        fsm_d.valid = 1'b1;
                        fsm_d.data  = fsm_q.shreg;
                    end else begin
                        fsm_d.pcnt = fsm_q.pcnt + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (wrap) begin
                    fsm_d.st    = ST_IDLE;
                    fsm_d.phase = '0;
                end else begin
                    fsm_d.phase = fsm_q.phase + 1'b1;
                end
            end
            default: fsm_d.st = ST_CONV_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q      <= '0;
            fsm_q.st   <= ST_CONV_RST;
            fsm_q.cs_n <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign cs_n_o  = fsm_q.cs_n;
    assign sclk_o  = fsm_q.sclk;
    assign busy_o  = (fsm_q.st != ST_IDLE);
    assign data_o  = fsm_q.data;
    assign valid_o = fsm_q.valid;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
    parameter int DATA_W  = 14,
    parameter int CLK_DIV = 2,
    parameter int RST_CYC = 16,
    parameter int PER_W   = 16,
    parameter int OVR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              guard2_i,
    input  logic              free_run_i,
    input  logic [PER_W-1:0]  period_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic [OVR_W-1:0]  overrun_o,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_fs,
    output logic              adc_rst,
    input  logic              adc_sdo
);
    logic conv_rst;
    logic tick;
    logic busy;

    adc_rst_seq #(.RST_CYC(RST_CYC)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_rst_o (conv_rst)
    );

    adc_rate_gen #(.PER_W(PER_W), .OVR_W(OVR_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (free_run_i),
        .period_i (period_i),
        .busy_i   (busy),
        .tick_o   (tick),
        .ovr_o    (overrun_o)
    );

    adc_frame_fsm #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_ready_i (!conv_rst),
        .req_i        (start_i || tick),
        .guard2_i     (guard2_i),
        .sdo_i        (adc_sdo),
        .cs_n_o       (adc_cs_n),
        .sclk_o       (adc_sclk),
        .busy_o       (busy),
        .data_o       (data_o),
        .valid_o      (valid_o)
    );

    assign busy_o  = busy;
    assign adc_rst = conv_rst;
    assign adc_fs  = 1'b1;
endmodule

// File: rtl/adc_frame_chk.sv
module adc_frame_chk #(
    parameter int OVR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             valid_o,
    input logic [OVR_W-1:0] overrun_o,
    input logic             adc_cs_n,
    input logic             adc_sclk,
    input logic             adc_rst
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk); // R4
    AST_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> busy_o); // R6
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |=> adc_cs_n); // R5
    AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(adc_cs_n)); // R8
    AST_END_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> valid_o); // R8
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R8
    AST_CONV_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rst |-> (adc_cs_n && busy_o)); // R2
    AST_NO_OVR_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (overrun_o >= $past(overrun_o))); // R10
endmodule

bind adc_frame_ctrl adc_frame_chk #(.OVR_W(OVR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .overrun_o (overrun_o),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_rst   (adc_rst)
);

// File: tb/sim_adc_frame_ctrl.sv
`timescale 1ns/1ps
module sim_adc_frame_ctrl;
    localparam int DW  = 14;
    localparam int DIV = 3;
    localparam int RC  = 5;
    localparam int PW  = 16;
    localparam int OW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          guard2_i = 1'b0;
    logic          free_run_i = 1'b0;
    logic [PW-1:0] period_i = '0;
    logic          busy_o;
    logic [DW-1:0] data_o;
    logic          valid_o;
    logic [OW-1:0] overrun_o;
    logic          adc_cs_n;
    logic          adc_sclk;
    logic          adc_fs;
    logic          adc_rst;
    logic          adc_sdo = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    logic [DW-1:0] conv_word = '0;
    int rises = 0;
    int rise_base = 0;
    int cs_falls = 0;
    int sclk_hi = 0;
    int sclk_bad = 0;

    always #4 clk = ~clk;

    adc_frame_ctrl #(.DATA_W(DW), .CLK_DIV(DIV), .RST_CYC(RC), .PER_W(PW), .OVR_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .guard2_i(guard2_i),
        .free_run_i(free_run_i), .period_i(period_i), .busy_o(busy_o),
        .data_o(data_o), .valid_o(valid_o), .overrun_o(overrun_o),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_fs(adc_fs),
        .adc_rst(adc_rst), .adc_sdo(adc_sdo)
    );

    // converter model: launches the next result bit on each serial clock rise
    always @(posedge adc_sclk) begin
        int idx;
        idx = rises - rise_base;
        if (!adc_cs_n)
            adc_sdo = (idx < DW) ? conv_word[DW-1-idx] : 1'b0;
        rises = rises + 1;
    end

    always @(negedge adc_cs_n) cs_falls = cs_falls + 1;

    always @(negedge clk) begin
        if (!adc_cs_n && adc_sclk) sclk_hi = sclk_hi + 1;
        if (adc_cs_n && adc_sclk) sclk_bad = sclk_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_frame(input logic [DW-1:0] word, input bit g2, input bit poke);
        int low = 0;
        int g = g2 ? 2 : 1;
        int falls0, hi0;
        conv_word = word;
        guard2_i  = g2;
        rise_base = rises;
        falls0    = cs_falls;
        hi0       = sclk_hi;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(adc_cs_n == 1'b0, "R3 cs low after start", adc_cs_n, 0);
        while (!adc_cs_n && low < 1000) begin
            low++;
            start_i = poke && (low == 4);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(low == DIV * (DW + g), "R3 cs low length", low, DIV * (DW + g));
        chk(rises - rise_base == DW + g, "R3 serial clock count", rises - rise_base, DW + g);
        chk(sclk_hi - hi0 == (DIV / 2) * (DW + g), "R4 high half length", sclk_hi - hi0, (DIV / 2) * (DW + g));
        chk(valid_o == 1'b1, "R8 valid at cs rise", valid_o, 1);
        chk(data_o == word, "R7 captured word", data_o, word);
        for (int i = 1; i < DIV; i++) begin
            @(negedge clk);
            chk(busy_o == 1'b1, "R5 busy through gap", busy_o, 1);
            chk(adc_cs_n == 1'b1, "R5 cs high in gap", adc_cs_n, 1);
        end
        @(negedge clk);
        chk(busy_o == 1'b0, "R5 busy falls after gap", busy_o, 0);
        chk(valid_o == 1'b0, "R8 valid single cycle", valid_o, 0);
        chk(data_o == word, "R8 data held", data_o, word);
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R6 no frame from busy start", adc_cs_n, 1);
        chk(cs_falls - falls0 == 1, "R6 one frame only", cs_falls - falls0, 1);
    endtask

    task automatic free_run(input int per, input int m);
        int falls0 = cs_falls;
        int ovr0 = overrun_o;
        int span = DIV * (DW + 1) + DIV;
        int busy_until = 0;
        int exp_acc = 0;
        int exp_drop = 0;
        for (int t = per; t <= m; t += per) begin
            if (t > busy_until) begin
                exp_acc++;
                busy_until = t + span;
            end else begin
                exp_drop++;
            end
        end
        guard2_i = 1'b0;
        conv_word = 14'h1234;
        rise_base = rises;
        period_i = PW'(per);
        @(negedge clk) free_run_i = 1'b1;
        repeat (m) @(posedge clk);
        @(negedge clk) free_run_i = 1'b0;
        repeat (span + 4) @(negedge clk);
        chk(cs_falls - falls0 == exp_acc, "R9 free-run frames", cs_falls - falls0, exp_acc);
        chk(int'(overrun_o) - ovr0 == exp_drop, "R10 overrun count", int'(overrun_o) - ovr0, exp_drop);
        chk(cs_falls - falls0 + int'(overrun_o) - ovr0 == m / per, "R10 requests balance",
            cs_falls - falls0 + int'(overrun_o) - ovr0, m / per);
    endtask

    initial begin
        logic [DW-1:0] lcg;
        int hi;
        // reset state, start held high throughout
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_cs_n == 1'b1, "R2 cs in reset", adc_cs_n, 1);
        chk(adc_sclk == 1'b0, "R4 sclk in reset", adc_sclk, 0);
        chk(adc_fs == 1'b1, "R1 fs in reset", adc_fs, 1);
        chk(busy_o == 1'b1, "R2 busy in reset", busy_o, 1);
        chk(adc_rst == 1'b1, "R2 conv reset asserted", adc_rst, 1);
        chk(valid_o == 1'b0, "R8 no valid in reset", valid_o, 0);
        rst_n = 1'b1;
        for (int i = 1; i < RC; i++) begin
            @(negedge clk);
            chk(adc_rst == 1'b1, "R2 conv reset held", adc_rst, 1);
            chk(adc_cs_n == 1'b1, "R2 no frame during conv reset", adc_cs_n, 1);
        end
        @(negedge clk);
        chk(adc_rst == 1'b0, "R2 conv reset ends", adc_rst, 0);
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R2 first frame not yet", adc_cs_n, 1);
        chk(busy_o == 1'b0, "R2 idle after conv reset", busy_o, 0);
        @(negedge clk);
        chk(adc_cs_n == 1'b0, "R2 held start accepted", adc_cs_n, 0);
        // back-to-back frames with start held
        guard2_i = 1'b0;
        while (!adc_cs_n) @(negedge clk);
        hi = 0;
        while (adc_cs_n && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        chk(hi == DIV + 1, "R11 back-to-back gap", hi, DIV + 1);
        start_i = 1'b0;
        wait_idle();
        // walking ones and fixed patterns, both guard settings
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < DW; b++) run_frame(DW'(1) << b, g[0], 1'b0);
            run_frame('0, g[0], 1'b1);
            run_frame('1, g[0], 1'b1);
            run_frame(14'h2AAA, g[0], 1'b0);
            run_frame(14'h1555, g[0], 1'b1);
        end
        // pseudo-random sweep
        lcg = 14'h0ACE;
        for (int n = 0; n < 300; n++) begin
            lcg = lcg * 14'd5 + 14'd3;
            run_frame(lcg ^ DW'(n * 37), n[0], (n % 3) == 0);
        end
        chk(sclk_bad == 0, "R4 sclk low while cs high", sclk_bad, 0);
        chk(adc_fs == 1'b1, "R1 fs high", adc_fs, 1);
        // free-running mode
        free_run(60, 600);
        free_run(20, 400);
        free_run(7, 210);
        chk(sclk_bad == 0, "R4 sclk low while cs high", sclk_bad, 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule